// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block connects a clocked host to an external asynchronous static RAM holding 128K bytes. The host issues one access at a time with a request/ready handshake: a request carries a read/write flag, a 17-bit address and, for writes, one byte. The controller captures these values, runs the memory's active-low chip-select, write-enable and output-enable lines through a fixed sequence of clock cycles, and then pulses ready. For a read, the ready pulse comes with the byte that was fetched.

Each memory timing limit is given in nanoseconds and converted to cycles at elaboration. The conversion rounds up and never gives fewer than one cycle. The limits cover read access, the width of the write strobe, data setup before the strobe ends, and the minimum write cycle. A parameter chooses which memory line carries the write strobe. One choice has write-enable close the write while chip-select stays low. The other has chip-select close the write while write-enable stays low.

When the block is idle, all three control lines are high, which puts the memory in standby. The output-enable line is held high throughout every write. Because of this, the controller's data drivers and the memory's outputs never drive the bus at the same time.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and in every cycle without an access, mem_cs_n, mem_we_n and mem_oe_n are 1, and mem_dq_oe and host_ready are 0.
- R2: A read is accepted on a clock edge where the block is idle and host_req=1 with host_we=0. Call that edge cycle 1. Starting from that edge, mem_cs_n and mem_oe_n are 0 and mem_we_n is 1 for exactly RD_CYC+2 cycles, where RD_CYC = max(1, ceil(T_RD_NS/CLK_NS)). host_ready is 1 in cycle RD_CYC+3, and host_rdata then holds the byte the memory drove at that address.
- R3: With STROBE_CS=0, a write keeps mem_cs_n at 0 for WP_CYC+2 cycles and mem_we_n at 0 for WP_CYC cycles, all inside the chip-select window. WP_CYC is the largest of ceil(T_WP_NS/CLK_NS), ceil(T_DW_NS/CLK_NS) and ceil(T_WC_NS/CLK_NS)-2, and is at least 1. host_ready is 1 in cycle WP_CYC+3.
- R4: With STROBE_CS=1, a write keeps mem_we_n at 0 for WP_CYC+2 cycles and mem_cs_n at 0 for WP_CYC cycles, all inside the write-enable window. host_ready is 1 in cycle WP_CYC+3.
- R5: mem_oe_n is 1 in every cycle where mem_we_n is 0 or mem_dq_oe is 1.
- R6: A write that comes after a completed read, with no write in between, first spends one cycle in which all control lines are 1 and mem_dq_oe is 0. This delays its ready by one cycle. mem_dq_oe rises only after mem_oe_n has been 1 for two cycles.
- R7: The address and write byte are latched when the request is accepted. Changes to host_addr, host_wdata, host_we or host_req during an access have no effect on that access, and mem_addr stays constant while mem_cs_n is 0.
- R8: host_ready is high for one cycle per completed access.
- R9: mem_dq_oe is 1 in every cycle where the write strobe is active (mem_cs_n=0 and mem_we_n=0), and also in the setup cycle before the strobe and the recovery cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, sampled only when idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address |
| host_wdata | input | DATA_W | Byte to write |
| host_rdata | output | DATA_W | Byte read, valid with host_ready |
| host_ready | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_o | output | DATA_W | Write data towards the pad |
| mem_dq_oe | output | 1 | Enable for the data pad drivers |
| mem_dq_i | input | DATA_W | Data returned from the pad |

## Verification
The bench runs two instances side by side, one for each strobe mode, and compares each against a behavioural memory model.

The main corner case is a write that follows a read. If the controller skipped the turnaround cycle, mem_dq_oe would rise one cycle early, just after the memory stopped driving, and the ready latency would come out one cycle short. The bench also counts the exact low window of each strobe in both modes. If the strobe carrier were swapped, or the windows were not nested, one of those counts would be wrong. If a write ended while the data drivers were already off, the memory would store the wrong byte, and the read-back would show it.

In the middle of a write, the bench changes the host address, data and direction. A controller that failed to latch them would write to the wrong location or turn the write into a read, and the read-back would expose that. Reads of untouched locations and of both address extremes check that all 17 address bits reach the memory.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_WAIT,
    ST_RD_CAPTURE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER,
    ST_TURNAROUND
  } ctl_state_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } pin_ctl_t;

  localparam pin_ctl_t PINS_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

  // Round a nanosecond limit up to whole clock cycles, never below one.
  function automatic int cycles_for(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_strobe.sv
module sram_ctl_strobe
  import sram_ctl_pkg::*;
#(
  parameter bit STROBE_CS = 1'b0
) (
  input  ctl_state_e state,
  output pin_ctl_t   pins
);
  logic in_rd, in_pulse, in_edge;
  logic cs_n_w, we_n_w;

  assign in_rd    = (state == ST_RD_SETUP) || (state == ST_RD_WAIT) || (state == ST_RD_CAPTURE);
  assign in_pulse = (state == ST_WR_PULSE);
  assign in_edge  = (state == ST_WR_SETUP) || (state == ST_WR_RECOVER);

  generate
    if (STROBE_CS) begin : g_cs_strobe
      // write-enable frames the access, chip-select carries the strobe
      assign cs_n_w = !(in_rd || in_pulse);
      assign we_n_w = !(in_pulse || in_edge);
    end else begin : g_we_strobe
      // chip-select frames the access, write-enable carries the strobe
      assign cs_n_w = !(in_rd || in_pulse || in_edge);
      assign we_n_w = !in_pulse;
    end
  endgenerate

  assign pins = '{cs_n: cs_n_w, we_n: we_n_w, oe_n: !in_rd, dq_oe: in_pulse || in_edge};
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 20,
  parameter int T_RD_NS   = 15,
  parameter int T_WP_NS   = 12,
  parameter int T_DW_NS   = 7,
  parameter int T_WC_NS   = 15,
  parameter bit STROBE_CS = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int RD_CYC  = cycles_for(T_RD_NS, CLK_NS);
  localparam int WP_BASE = max2(cycles_for(T_WP_NS, CLK_NS), cycles_for(T_DW_NS, CLK_NS));
  localparam int WP_CYC  = max2(WP_BASE, cycles_for(T_WC_NS, CLK_NS) - 2);
  localparam int CNT_W   = $clog2(max2(RD_CYC, WP_CYC) + 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYC - 1);

  ctl_state_e       state_q, state_d;
  pin_ctl_t         pins_d, pins_q;
  logic             accept, after_rd_q;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;

  assign accept   = (state_q == ST_IDLE) && host_req;
  assign tmr_load = (state_q == ST_RD_SETUP) || (state_q == ST_WR_SETUP);
  assign tmr_val  = (state_q == ST_RD_SETUP) ? RD_LOAD : WP_LOAD;

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (host_req) begin
        if (!host_we)        state_d = ST_RD_SETUP;
        else if (after_rd_q) state_d = ST_TURNAROUND;
        else                 state_d = ST_WR_SETUP;
      end
      ST_RD_SETUP:   state_d = ST_RD_WAIT;
      ST_RD_WAIT:    if (tmr_done) state_d = ST_RD_CAPTURE;
      ST_RD_CAPTURE: state_d = ST_IDLE;
      ST_TURNAROUND: state_d = ST_WR_SETUP;
      ST_WR_SETUP:   state_d = ST_WR_PULSE;
      ST_WR_PULSE:   if (tmr_done) state_d = ST_WR_RECOVER;
      ST_WR_RECOVER: state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  // Pin levels are decoded from the next state and registered.
  sram_ctl_strobe #(.STROBE_CS(STROBE_CS)) u_strobe (
    .state (state_d),
    .pins  (pins_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      pins_q     <= PINS_IDLE;
      host_ready <= 1'b0;
      host_rdata <= '0;
      mem_addr   <= '0;
      mem_dq_o   <= '0;
      after_rd_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      pins_q     <= pins_d;
      host_ready <= (state_q == ST_RD_CAPTURE) || (state_q == ST_WR_RECOVER);
      if (state_q == ST_RD_CAPTURE) host_rdata <= mem_dq_i;
      if (accept) begin
        mem_addr <= host_addr;
        mem_dq_o <= host_wdata;
      end
      if (state_q == ST_RD_CAPTURE)    after_rd_q <= 1'b1;
      else if (state_q == ST_WR_SETUP) after_rd_q <= 1'b0;
    end
  end

  assign mem_cs_n  = pins_q.cs_n;
  assign mem_we_n  = pins_q.we_n;
  assign mem_oe_n  = pins_q.oe_n;
  assign mem_dq_oe = pins_q.dq_oe;

  // R5
  oe_drive_excl_chk: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);
  // R5
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);
  // R2
  read_ctl_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_cs_n && mem_we_n));
  // R9
  drive_covers_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && !mem_we_n) |-> mem_dq_oe);
  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    host_ready |=> !host_ready);
  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
  // R6
  turnaround_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> ($past(mem_oe_n) && $past(mem_oe_n, 2)));

  generate
    if (STROBE_CS) begin : g_cs_order
      // R4
      cs_inside_we_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_cs_n && mem_dq_oe |-> !mem_we_n);
    end else begin : g_we_order
      // R3
      we_inside_cs_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_cs_n);
    end
  endgenerate
endmodule

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps

module asram_model #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] mem [logic [AW-1:0]];
  logic wr_prev = 1'b0;

  // A write is committed when the strobe window closes.
  always @(negedge clk) begin
    if (wr_prev && !(!cs_n && !we_n)) mem[addr] = din;
    wr_prev = !cs_n && !we_n;
    if (!cs_n && we_n && !oe_n && mem.exists(addr)) dout = mem[addr];
    else dout = '0;
  end
endmodule

module asram_ctrl_tb;
  localparam int CLK_NS = 20;
  localparam int RD_C   = (15 + CLK_NS - 1) / CLK_NS < 1 ? 1 : (15 + CLK_NS - 1) / CLK_NS;
  localparam int WP_A   = (12 + CLK_NS - 1) / CLK_NS;
  localparam int WP_B   = (7 + CLK_NS - 1) / CLK_NS;
  localparam int WP_C   = (15 + CLK_NS - 1) / CLK_NS - 2;
  localparam int WP_AB  = WP_A > WP_B ? WP_A : WP_B;
  localparam int WP_ABC = WP_AB > WP_C ? WP_AB : WP_C;
  localparam int WP_CY  = WP_ABC < 1 ? 1 : WP_ABC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, hwe = 1'b0;
  logic [16:0] haddr = '0;
  logic [7:0]  hwdata = '0;

  logic [7:0]  rdata [2];
  logic        rdy   [2];
  logic [16:0] maddr [2];
  logic        cs_n  [2], we_n [2], oe_n [2], dqoe [2];
  logic [7:0]  dqo   [2], dqi [2];

  int n_chk = 0, n_fail = 0;
  bit reported = 1'b0;
  bit last_rd = 1'b0;
  logic [7:0] ref_mem [logic [16:0]];

  always #10 clk = ~clk;

  asram_ctrl #(.CLK_NS(CLK_NS), .STROBE_CS(1'b0)) u_dut (
    .clk(clk), .rst(rst), .host_req(req), .host_we(hwe), .host_addr(haddr),
    .host_wdata(hwdata), .host_rdata(rdata[0]), .host_ready(rdy[0]),
    .mem_addr(maddr[0]), .mem_cs_n(cs_n[0]), .mem_we_n(we_n[0]), .mem_oe_n(oe_n[0]),
    .mem_dq_o(dqo[0]), .mem_dq_oe(dqoe[0]), .mem_dq_i(dqi[0]));

  asram_ctrl #(.CLK_NS(CLK_NS), .STROBE_CS(1'b1)) u_dut_cs (
    .clk(clk), .rst(rst), .host_req(req), .host_we(hwe), .host_addr(haddr),
    .host_wdata(hwdata), .host_rdata(rdata[1]), .host_ready(rdy[1]),
    .mem_addr(maddr[1]), .mem_cs_n(cs_n[1]), .mem_we_n(we_n[1]), .mem_oe_n(oe_n[1]),
    .mem_dq_o(dqo[1]), .mem_dq_oe(dqoe[1]), .mem_dq_i(dqi[1]));

  asram_model u_mem0 (.clk(clk), .cs_n(cs_n[0]), .we_n(we_n[0]), .oe_n(oe_n[0]),
                      .addr(maddr[0]), .din(dqo[0]), .dout(dqi[0]));
  asram_model u_mem1 (.clk(clk), .cs_n(cs_n[1]), .we_n(we_n[1]), .oe_n(oe_n[1]),
                      .addr(maddr[1]), .din(dqo[1]), .dout(dqi[1]));

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // R5: contention monitor on both instances
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < 2; i++) begin
        if ((dqoe[i] || !we_n[i]) && !oe_n[i]) begin
          n_fail++;
          $display("FAIL R5 inst %0d: oe_n actual %0d expected 1", i, oe_n[i]);
        end
      end
    end
  end

  task automatic t_idle(input int n);
    bit ok = 1'b1;
    req = 1'b0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      for (int i = 0; i < 2; i++)
        if (!(cs_n[i] && we_n[i] && oe_n[i] && !dqoe[i] && !rdy[i])) ok = 1'b0;
    end
    chk(ok, "R1", "pins idle / no ready", ok, 1);
  endtask

  task automatic t_write(input logic [16:0] a, input logic [7:0] d, input bit scramble);
    int k = 0;
    int lo_cs [2];
    int lo_we [2];
    bit seen = 1'b0, oe_ok = 1'b1, first_ok = 1'b1, drv_ok = 1'b1;
    bit turn = last_rd;
    lo_cs = '{0, 0};
    lo_we = '{0, 0};
    req = 1'b1; hwe = 1'b1; haddr = a; hwdata = d;
    while (!seen && k < 50) begin
      @(negedge clk);
      k++;
      for (int i = 0; i < 2; i++) begin
        if (!cs_n[i]) lo_cs[i]++;
        if (!we_n[i]) lo_we[i]++;
        if (!oe_n[i]) oe_ok = 1'b0;
        if (k == 1 && dqoe[i] != !turn) first_ok = 1'b0;
        if (!cs_n[i] && !we_n[i] && !dqoe[i]) drv_ok = 1'b0;
      end
      if (k == 1 && scramble) begin
        haddr = ~a; hwdata = ~d; hwe = 1'b0;
      end
      if (rdy[0]) begin
        seen = 1'b1;
        chk(rdy[1], "R4", "cs-strobe ready with we-strobe ready", rdy[1], 1);
      end
    end
    req = 1'b0;
    chk(k == WP_CY + 3 + int'(turn), turn ? "R6" : "R3", "write ready latency", k, WP_CY + 3 + int'(turn));
    chk(first_ok, "R6", "drive enable in first cycle", first_ok, 1);
    chk(oe_ok, "R5", "oe_n held high during write", oe_ok, 1);
    chk(drv_ok, "R9", "data driven under strobe", drv_ok, 1);
    chk(lo_we[0] == WP_CY && lo_cs[0] == WP_CY + 2, "R3", "we-strobe low cycles (we)", lo_we[0], WP_CY);
    chk(lo_cs[0] == WP_CY + 2, "R3", "we-strobe low cycles (cs)", lo_cs[0], WP_CY + 2);
    chk(lo_cs[1] == WP_CY, "R4", "cs-strobe low cycles (cs)", lo_cs[1], WP_CY);
    chk(lo_we[1] == WP_CY + 2, "R4", "cs-strobe low cycles (we)", lo_we[1], WP_CY + 2);
    @(negedge clk);
    chk(!rdy[0] && !rdy[1], "R8", "ready single cycle after write", rdy[0], 0);
    ref_mem[a] = d;
    last_rd = 1'b0;
  endtask

  task automatic t_read(input logic [16:0] a);
    int k = 0;
    int lo_cs [2];
    bit seen = 1'b0, we_ok = 1'b1, drv_ok = 1'b1;
    logic [7:0] exp;
    lo_cs = '{0, 0};
    exp = ref_mem.exists(a) ? ref_mem[a] : 8'h00;
    req = 1'b1; hwe = 1'b0; haddr = a; hwdata = 8'h5A;
    while (!seen && k < 50) begin
      @(negedge clk);
      k++;
      for (int i = 0; i < 2; i++) begin
        if (!cs_n[i]) begin
          lo_cs[i]++;
          if (oe_n[i]) we_ok = 1'b0;
        end
        if (!we_n[i]) we_ok = 1'b0;
        if (dqoe[i]) drv_ok = 1'b0;
      end
      if (rdy[0]) seen = 1'b1;
    end
    req = 1'b0;
    chk(k == RD_C + 3, "R2", "read ready latency", k, RD_C + 3);
    chk(we_ok && drv_ok, "R2", "read pin levels", we_ok && drv_ok, 1);
    for (int i = 0; i < 2; i++) begin
      chk(lo_cs[i] == RD_C + 2, "R2", "read cs low cycles", lo_cs[i], RD_C + 2);
      chk(rdy[i] && rdata[i] == exp, "R2", "read data", rdata[i], exp);
    end
    @(negedge clk);
    chk(!rdy[0] && !rdy[1], "R8", "ready single cycle after read", rdy[0], 0);
    last_rd = 1'b1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 2; i++)
      chk(cs_n[i] && we_n[i] && oe_n[i] && !dqoe[i] && !rdy[i], "R1", "reset pin state",
          {cs_n[i], we_n[i], oe_n[i], dqoe[i], rdy[i]}, 5'b11100);
    rst = 1'b0;
    t_idle(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    t_reset();
    t_write(17'h00123, 8'hA7, 1'b0);
    t_write(17'h10456, 8'h3C, 1'b0);
    t_read(17'h00123);
    t_write(17'h0ABCD, 8'h96, 1'b0);   // R6: follows a read
    t_read(17'h10456);
    t_read(17'h0ABCD);
    t_read(17'h05555);                 // never written
    t_idle(3);
    t_write(17'h1F00F, 8'hE1, 1'b1);   // R6 and R7: host inputs change mid-access
    t_read(17'h1F00F);
    t_read(~17'h1F00F);                // R7: scrambled address untouched
    t_write(17'h1FFFF, 8'hFF, 1'b0);   // R6: after a read again
    t_write(17'h00000, 8'h01, 1'b0);
    t_read(17'h1FFFF);
    t_read(17'h00000);
    t_idle(4);
    report();
  end
endmodule